// File: doc/BRIEF.md
# Refresh-Interleaved Register File Sequencer

This block sequences a 32-row by 32-bit register file whose cells slowly lose their charge. Each instruction takes a fixed frame of eight clock cycles. A fetch strobe opens a frame and captures the two source register numbers, the destination register number, the write-enable and the write word. The frame then walks through four storage accesses. Each access is followed by a quiet settling cycle in which no row is driven.

The first access of every frame refreshes the row named by an internal wrapping counter. With back-to-back frames, every row is therefore revisited once every 256 cycles. The remaining accesses read the first source, read the second source and write the destination. One multiplexer chooses the row number for each access, and a 5-to-32 one-hot decoder turns it into row selects. A read also restores the row it senses, so any access counts as a refresh of that row. Row 0 is the constant-zero register.

The storage is a behavioural model. Each data row keeps an age counter, and a sticky flag reports any row that went unvisited longer than the retention limit.

Top module: `regfile_refresh_seq`

## Requirements
- R1: After reset, busy is 0, row_sel is all-zero, fb_disable is 1, both read words are 0, retention_err is 0 and every stored row holds 0.
- R2: A fetch is accepted when busy is 0 or when slot is 7. The register numbers, write-enable and write word are captured at that edge, and the next cycle is slot 0 with busy 1. A fetch at any other time is ignored, and the frame that is running continues unchanged.
- R3: While busy, slot counts 0,1,...,7 on consecutive cycles. Slot 0 is refresh, 2 is the first-source read, 4 is the second-source read and 6 is the write; odd slots settle. After slot 7 without an accepted fetch, busy drops to 0.
- R4: In slot 0, row_sel selects the row given by the refresh counter. The counter is 0 after reset, advances by one per frame and wraps from 31 to 0.
- R5: In every odd slot and while idle, row_sel is all-zero.
- R6: Slot 2 selects the captured first-source row, and rs1_data takes that row's stored word on the following edge. Slot 4 does the same for the second source and rs2_data. Each read word is held until its slot in the next frame.
- R7: Slot 6 selects the captured destination row when write-enable was captured as 1 and the destination is nonzero, and that row takes the write word at the end of slot 6. Reads in the same frame return the value the row held before the write.
- R8: A write aimed at row 0 selects no row in slot 6 and changes nothing. A read of row 0 returns 0.
- R9: fb_disable is 0 in every access slot (0, 2, 4, 6) and 1 in settling slots and while idle, so feedback is never disabled during a write.
- R10: Every data row (1 to 31) has an age that clears when the row is selected. retention_err becomes 1 once any age exceeds AGE_LIMIT cycles (default 400) and stays 1 until reset. Back-to-back frames never set it.
- R11: row_sel bit i drives row i, and at most one bit is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch | input | 1 | Instruction fetch strobe; opens a frame |
| rs1_idx | input | 5 | First source register number |
| rs2_idx | input | 5 | Second source register number |
| rd_idx | input | 5 | Destination register number |
| wr_en | input | 1 | Destination write enable |
| wr_data | input | 32 | Word to write to the destination |
| busy | output | 1 | A frame is in progress |
| slot | output | 3 | Current slot of the frame |
| row_sel | output | 32 | One-hot row select from the decoder |
| fb_disable | output | 1 | Column feedback disable |
| rs1_data | output | 32 | First source word |
| rs2_data | output | 32 | Second source word |
| retention_err | output | 1 | Sticky flag: a row outlived its retention limit |

## Verification
The hardest situation to reach from the ports is a retention failure, because it only appears once a row has gone unvisited for more than 400 cycles. Back-to-back frames never allow that. The stimulus first runs over 300 chained frames, taking the refresh counter through several wraps with no error, and then withholds fetches for 700 cycles to starve refresh and confirm that the flag sets and stays set. A stray fetch in the middle of a frame, reads of a row in the same frame that writes it, and writes aimed at row 0 are added as directed frames among random ones.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  localparam int SLOT_W = 3;

  typedef enum logic [SLOT_W-1:0] {
    SL_REFRESH = 3'd0,
    SL_SET_A   = 3'd1,
    SL_READ_A  = 3'd2,
    SL_SET_B   = 3'd3,
    SL_READ_B  = 3'd4,
    SL_SET_C   = 3'd5,
    SL_WRITE   = 3'd6,
    SL_SET_D   = 3'd7
  } slot_e;

  // Even slots touch storage, odd slots let the columns settle.
  function automatic logic slot_is_access(input logic [SLOT_W-1:0] s);
    return ~s[0];
  endfunction

  function automatic logic slot_is_last(input logic [SLOT_W-1:0] s);
    return s == SL_SET_D;
  endfunction
endpackage

// File: rtl/rfs_slot_ctrl.sv
module rfs_slot_ctrl
  import rfs_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch,
  input  logic [IDX_W-1:0]  rs1_i,
  input  logic [IDX_W-1:0]  rs2_i,
  input  logic [IDX_W-1:0]  rd_i,
  input  logic              we_i,
  input  logic [WIDTH-1:0]  wd_i,
  output logic              busy,
  output logic [SLOT_W-1:0] slot,
  output logic [IDX_W-1:0]  rs1_q,
  output logic [IDX_W-1:0]  rs2_q,
  output logic [IDX_W-1:0]  rd_q,
  output logic              we_q,
  output logic [WIDTH-1:0]  wd_q,
  output logic [IDX_W-1:0]  refcnt,
  output logic              accept,
  output logic              refresh_cycle
);
  assign accept        = fetch && (!busy || slot_is_last(slot));
  assign refresh_cycle = busy && (slot == SL_REFRESH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      slot   <= SL_REFRESH;
      rs1_q  <= '0;
      rs2_q  <= '0;
      rd_q   <= '0;
      we_q   <= 1'b0;
      wd_q   <= '0;
      refcnt <= '0;
    end else begin
      if (accept) begin
        busy  <= 1'b1;
        slot  <= SL_REFRESH;
        rs1_q <= rs1_i;
        rs2_q <= rs2_i;
        rd_q  <= rd_i;
        we_q  <= we_i;
        wd_q  <= wd_i;
      end else if (busy) begin
        if (slot_is_last(slot)) busy <= 1'b0;
        else                    slot <= slot + 3'd1;
      end
      if (refresh_cycle) refcnt <= refcnt + 1'b1;
    end
  end
endmodule

// File: rtl/rfs_row_decoder.sv
module rfs_row_decoder
  import rfs_pkg::*;
#(
  parameter int ROWS  = 32,
  parameter int IDX_W = 5
) (
  input  logic              busy,
  input  logic [SLOT_W-1:0] slot,
  input  logic [IDX_W-1:0]  refcnt,
  input  logic [IDX_W-1:0]  rs1_q,
  input  logic [IDX_W-1:0]  rs2_q,
  input  logic [IDX_W-1:0]  rd_q,
  input  logic              we_q,
  output logic [ROWS-1:0]   row_sel,
  output logic              wr_cycle
);
  logic [IDX_W-1:0] src_row;
  logic             active;

  // Row-number multiplexer shared by the four access kinds.
  always_comb begin
    case (slot)
      SL_REFRESH: src_row = refcnt;
      SL_READ_A:  src_row = rs1_q;
      SL_READ_B:  src_row = rs2_q;
      default:    src_row = rd_q;
    endcase
  end

  assign wr_cycle = busy && (slot == SL_WRITE) && we_q && (rd_q != '0);
  assign active   = busy && slot_is_access(slot) &&
                    ((slot != SL_WRITE) || wr_cycle);

  for (genvar i = 0; i < ROWS; i++) begin : g_dec
    assign row_sel[i] = active && (src_row == IDX_W'(i));
  end
endmodule

// File: rtl/rfs_cell_array.sv
module rfs_cell_array #(
  parameter int ROWS      = 32,
  parameter int WIDTH     = 32,
  parameter int AGE_LIMIT = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROWS-1:0]  row_sel,
  input  logic             wr_cycle,
  input  logic [WIDTH-1:0] wr_word,
  output logic [WIDTH-1:0] rd_word,
  output logic             retention_err
);
  localparam int AGE_MAX = AGE_LIMIT + 1;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);

  logic [WIDTH-1:0] mem_q [ROWS];
  logic [AGE_W-1:0] age_q [ROWS];
  logic [ROWS-1:0]  expired;

  function automatic logic [AGE_W-1:0] age_step(input logic [AGE_W-1:0] a);
    return (a >= AGE_W'(AGE_MAX)) ? a : a + 1'b1;
  endfunction

  // Row 0 is never written: it keeps its reset value of zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        mem_q[r] <= '0;
        age_q[r] <= '0;
      end
    end else begin
      for (int r = 1; r < ROWS; r++) begin
        if (wr_cycle && row_sel[r]) mem_q[r] <= wr_word;
        if (row_sel[r]) age_q[r] <= '0;
        else            age_q[r] <= age_step(age_q[r]);
      end
    end
  end

  always_comb begin
    rd_word    = '0;
    expired    = '0;
    for (int r = 0; r < ROWS; r++) begin
      rd_word = rd_word | (mem_q[r] & {WIDTH{row_sel[r]}});
      if (r != 0) expired[r] = age_q[r] > AGE_W'(AGE_LIMIT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          retention_err <= 1'b0;
    else if (|expired)   retention_err <= 1'b1;
  end
endmodule

// File: rtl/regfile_refresh_seq.sv
module regfile_refresh_seq
  import rfs_pkg::*;
#(
  parameter int ROWS      = 32,
  parameter int WIDTH     = 32,
  parameter int AGE_LIMIT = 400,
  localparam int IDX_W    = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch,
  input  logic [IDX_W-1:0]  rs1_idx,
  input  logic [IDX_W-1:0]  rs2_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  output logic              busy,
  output logic [SLOT_W-1:0] slot,
  output logic [ROWS-1:0]   row_sel,
  output logic              fb_disable,
  output logic [WIDTH-1:0]  rs1_data,
  output logic [WIDTH-1:0]  rs2_data,
  output logic              retention_err
);
  logic [IDX_W-1:0] rs1_q, rs2_q, rd_q, refcnt;
  logic             we_q, accept, refresh_cycle, wr_cycle;
  logic [WIDTH-1:0] wd_q, rd_word;
  logic             rs1_zero_read;

  rfs_slot_ctrl #(.IDX_W(IDX_W), .WIDTH(WIDTH)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .fetch(fetch),
    .rs1_i(rs1_idx), .rs2_i(rs2_idx), .rd_i(rd_idx), .we_i(wr_en), .wd_i(wr_data),
    .busy(busy), .slot(slot), .rs1_q(rs1_q), .rs2_q(rs2_q), .rd_q(rd_q),
    .we_q(we_q), .wd_q(wd_q), .refcnt(refcnt), .accept(accept),
    .refresh_cycle(refresh_cycle)
  );

  rfs_row_decoder #(.ROWS(ROWS), .IDX_W(IDX_W)) i_dec (
    .busy(busy), .slot(slot), .refcnt(refcnt), .rs1_q(rs1_q), .rs2_q(rs2_q),
    .rd_q(rd_q), .we_q(we_q), .row_sel(row_sel), .wr_cycle(wr_cycle)
  );

  rfs_cell_array #(.ROWS(ROWS), .WIDTH(WIDTH), .AGE_LIMIT(AGE_LIMIT)) i_cells (
    .clk(clk), .rst_n(rst_n), .row_sel(row_sel), .wr_cycle(wr_cycle),
    .wr_word(wd_q), .rd_word(rd_word), .retention_err(retention_err)
  );

  assign fb_disable    = !(busy && slot_is_access(slot));
  assign rs1_zero_read = busy && (slot == SL_READ_A) && (rs1_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_data <= '0;
      rs2_data <= '0;
    end else if (busy) begin
      if (slot == SL_READ_A) rs1_data <= rd_word;
      if (slot == SL_READ_B) rs2_data <= rd_word;
    end
  end

  logic unused_accept;
  assign unused_accept = accept;
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
  parameter int ROWS  = 32,
  parameter int WIDTH = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch,
  input logic             busy,
  input logic [2:0]       slot,
  input logic [ROWS-1:0]  row_sel,
  input logic             fb_disable,
  input logic [WIDTH-1:0] rs1_data,
  input logic [IDX_W-1:0] refcnt,
  input logic             wr_cycle,
  input logic             refresh_cycle,
  input logic             rs1_zero_read,
  input logic             retention_err
);
  p_onehot_rows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel));

  p_settle_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !slot[0]) |=> (row_sel == '0));

  p_slot_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot != 3'd7) |=> (busy && slot == $past(slot) + 3'd1));

  p_frame_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot == 3'd7 && !fetch) |=> !busy);

  p_refresh_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_cycle |=> (refcnt == $past(refcnt) + 1'b1));

  p_feedback_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cycle |-> (!fb_disable && row_sel != '0));

  p_row0_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rs1_zero_read |=> (rs1_data == '0));

  p_error_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    retention_err |=> retention_err);
endmodule

bind regfile_refresh_seq rfs_checker #(.ROWS(ROWS), .WIDTH(WIDTH), .IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .fetch(fetch), .busy(busy), .slot(slot),
  .row_sel(row_sel), .fb_disable(fb_disable), .rs1_data(rs1_data),
  .refcnt(refcnt), .wr_cycle(wr_cycle), .refresh_cycle(refresh_cycle),
  .rs1_zero_read(rs1_zero_read), .retention_err(retention_err)
);

// File: tb/test_regfile_refresh_seq.sv
module test_regfile_refresh_seq;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch = 1'b0;
  logic [4:0]  rs1_idx = '0, rs2_idx = '0, rd_idx = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        busy, fb_disable, retention_err;
  logic [2:0]  slot;
  logic [31:0] row_sel, rs1_data, rs2_data;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_mem [32];
  logic [4:0]  exp_ref = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile_refresh_seq i_regfile_refresh_seq (
    .clk(clk), .rst_n(rst_n), .fetch(fetch), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
    .rd_idx(rd_idx), .wr_en(wr_en), .wr_data(wr_data), .busy(busy), .slot(slot),
    .row_sel(row_sel), .fb_disable(fb_disable), .rs1_data(rs1_data),
    .rs2_data(rs2_data), .retention_err(retention_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] read_model(input logic [4:0] r);
    return (r == 5'd0) ? 32'd0 : exp_mem[r];
  endfunction

  function automatic logic [31:0] sel_model(input int s, input logic [4:0] a, input logic [4:0] b,
                                            input logic [4:0] d, input logic we);
    case (s)
      0: return 32'd1 << exp_ref;
      2: return 32'd1 << a;
      4: return 32'd1 << b;
      6: return (we && d != 5'd0) ? (32'd1 << d) : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  // Called at a falling edge where a fetch would be accepted; returns at the
  // falling edge of slot 7 of the frame it started.
  task automatic run_frame(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d,
                           input logic we, input logic [31:0] wd, input bit glitch);
    logic [31:0] ea, eb, es;
    string tag;
    ea = read_model(a);
    eb = read_model(b);
    rs1_idx = a; rs2_idx = b; rd_idx = d; wr_en = we; wr_data = wd; fetch = 1'b1;
    @(posedge clk);
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      if (s == 0) fetch = 1'b0;
      chk(busy && slot == 3'(s), glitch ? "R2 R3 slot sequence" : "R3 slot sequence",
          {busy, slot}, {1'b1, 3'(s)});
      es = sel_model(s, a, b, d, we);
      if (s == 0)           tag = "R4 refresh row";
      else if (s[0])        tag = "R5 settle row";
      else if (s == 6)      tag = (d == 5'd0) ? "R8 row0 write" : "R7 write row";
      else                  tag = "R6 R11 read row";
      chk(row_sel == es, tag, row_sel, es);
      chk(fb_disable == s[0], "R9 feedback disable", fb_disable, s[0]);
      if (s == 3) chk(rs1_data == ea, (a == 0) ? "R8 row0 read" : "R6 rs1 data", rs1_data, ea);
      if (s == 5) chk(rs2_data == eb, (b == 0) ? "R8 row0 read" : "R6 rs2 data", rs2_data, eb);
      if (glitch && s == 3) begin
        fetch = 1'b1; rs1_idx = ~a; rs2_idx = ~b; rd_idx = ~d; wr_data = ~wd;
      end
      if (glitch && s == 4) fetch = 1'b0;
    end
    exp_ref = exp_ref + 5'd1;
    if (we && d != 5'd0) exp_mem[d] = wd;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd5150);
    for (int r = 0; r < 32; r++) exp_mem[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && row_sel == '0 && fb_disable && !retention_err, "R1 reset outputs",
        {busy, fb_disable, retention_err}, 3'b010);
    chk(rs1_data == '0 && rs2_data == '0, "R1 reset read words", {rs1_data, rs2_data}, 64'd0);

    // Directed frames.
    run_frame(5'd3, 5'd4, 5'd5, 1'b1, 32'hA5A5_0F0F, 1'b0);
    run_frame(5'd5, 5'd5, 5'd5, 1'b1, 32'h1234_5678, 1'b0); // reads see old value (R7)
    run_frame(5'd5, 5'd0, 5'd0, 1'b1, 32'hFFFF_FFFF, 1'b0); // write to row 0 ignored
    run_frame(5'd0, 5'd0, 5'd31, 1'b1, 32'hDEAD_BEEF, 1'b1); // stray fetch mid-frame
    run_frame(5'd31, 5'd5, 5'd7, 1'b0, 32'h0BAD_F00D, 1'b0);

    // Random frames, back to back.
    for (int n = 0; n < 300; n++) begin
      logic [4:0] a, b, d;
      a = 5'($urandom_range(0, 31));
      b = 5'($urandom_range(0, 31));
      d = 5'($urandom_range(0, 31));
      run_frame(a, b, d, 1'($urandom_range(0, 1)), $urandom(), ($urandom_range(0, 15) == 0));
    end
    chk(!retention_err, "R10 no error under steady refresh", retention_err, 1'b0);

    // Starve refresh.
    @(negedge clk);
    chk(!busy && row_sel == '0 && fb_disable, "R3 R5 idle after last frame",
        {busy, fb_disable}, 2'b01);
    repeat (700) @(negedge clk);
    chk(retention_err, "R10 error after starvation", retention_err, 1'b1);
    run_frame(5'd1, 5'd2, 5'd3, 1'b1, 32'h0000_0001, 1'b0);
    @(negedge clk);
    chk(retention_err, "R10 error stays set", retention_err, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule